// File: doc/BRIEF.md
# Addressed Serial Display Data Receiver

This block takes display contents for a two-digit fluorescent display from a host controller over three wires: a serial clock, a serial data line and an enable line. While the enable line is low, the receiver collects an 8-bit device address. When the enable goes high, it shifts in a payload. When the enable falls, it commits that payload to the output registers, but only if the last address it saw is the device code 0x21 and exactly 64 payload bits arrived. Any other frame is dropped.

A full display image takes two frames. A select bit in each payload marks which one it is. The first frame carries the 53 segment bits of digit one. The second frame carries the 53 segment bits of digit two plus a 10-bit dimmer word. The committed registers feed the display timing logic, which lies outside this block. An active-low blanking input forces the segment outputs to zero while reception and commits go on as normal.

All three serial lines pass through two-flop synchronizers into the system clock domain. For this reason the system clock must run at least four times faster than the serial clock.

Top module: `vfd_serial_rx`

## Requirements
- R1: While reset is held, and directly after it, all segment outputs and the dimmer output are zero.
- R2: While the enable is low, each rising serial clock edge shifts in one address bit, least significant bit first. A frame is accepted only when the last eight such bits before the enable rises equal 0x21. A frame with any other address leaves all outputs unchanged.
- R3: While the enable is high, each rising serial clock edge shifts in one payload bit, least significant bit first, for 64 bits (payload bits 0 to 63). Payload bit 63 selects the frame. When it is 0, digit-one segments 1 to 53 are loaded from payload bits 0 to 52, and bits 53 to 62 are ignored.
- R4: When payload bit 63 is 1, digit-two segments 1 to 53 are loaded from payload bits 0 to 52. The dimmer is loaded from payload bits 53 to 62, with its least significant bit at payload bit 53.
- R5: A frame is committed only when the enable falls and exactly 64 payload bits have arrived. A frame of 63 or 65 bits changes nothing.
- R6: A frame updates only its own fields. A digit-one frame leaves the digit-two segments and the dimmer unchanged, and a digit-two frame leaves the digit-one segments unchanged.
- R7: Reception gives the same result whether the serial clock rests high or low between bits and around enable changes.
- R8: While the blanking input is low, both segment outputs read zero and the dimmer output is unaffected. Frames received during blanking still commit, and their contents appear once blanking is released.
- R9: Committed values appear at the outputs on the third system clock rising edge after the enable falls, counted from the first edge that sees it low. They do not change at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock from the host |
| ser_dat_i | input | 1 | Serial data, sampled on the rising serial clock |
| ser_en_i | input | 1 | Enable: low for the address, high for the payload |
| blank_n_i | input | 1 | Active-low blanking of the segment outputs |
| seg_g1_o | output | 53 | Digit-one segments, bit 0 is segment 1 |
| seg_g2_o | output | 53 | Digit-two segments, bit 0 is segment 1 |
| dimmer_o | output | 10 | Brightness word |

## Verification
Each serial line takes two register stages to synchronize and one stage for edge detection. As a result, a committed field reaches its output register on the third system clock edge after the enable falls, while the blanking mask acts in the same cycle. The bench changes every input on a falling system clock edge and reads the outputs on later falling edges. In the latency test it reads once after the second rising edge, where the old value must still hold, and once after the third, where the new value must be present. All other frames are checked six cycles after the enable falls, which is well past the commit point.

// File: rtl/vfdrx_pkg.sv
package vfdrx_pkg;
  localparam int ADDR_W    = 8;
  localparam int PAYLOAD_W = 64;
  localparam int SEG_N     = 53;
  localparam int DIM_W     = 10;
  localparam logic [ADDR_W-1:0] DEV_CODE = 8'h21;
  localparam int SEL_POS   = PAYLOAD_W - 1;
  localparam int DIM_LSB   = SEG_N;
  localparam int CNT_W     = $clog2(PAYLOAD_W + 2);

  typedef enum logic {FRAME_DIGIT1 = 1'b0, FRAME_DIGIT2 = 1'b1} frame_sel_e;
endpackage

// File: rtl/vfdrx_sync.sv
module vfdrx_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic s1_q, s2_q, s3_q;
      logic s1_d, s2_d, s3_d;

      always_comb begin
        s1_d = async_i[g];
        s2_d = s1_q;
        s3_d = s2_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
          s3_q <= 1'b0;
        end else begin
          s1_q <= s1_d;
          s2_q <= s2_d;
          s3_q <= s3_d;
        end
      end

      assign level_o[g] = s2_q;
      assign rise_o[g]  = s2_q & ~s3_q;
      assign fall_o[g]  = ~s2_q & s3_q;
    end
  endgenerate
endmodule

// File: rtl/vfdrx_shifter.sv
module vfdrx_shifter
  import vfdrx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_strobe_i,
  input  logic                 bit_val_i,
  input  logic                 en_level_i,
  input  logic                 en_rise_i,
  input  logic                 en_fall_i,
  output logic [PAYLOAD_W-1:0] payload_o,
  output logic                 accept_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAYLOAD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(PAYLOAD_W + 1);

  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic                 match_q, match_d;
  logic [PAYLOAD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  always_comb begin
    addr_d  = addr_q;
    match_d = match_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (en_rise_i) begin
      match_d = (addr_q == DEV_CODE);
      cnt_d   = '0;
    end else if (bit_strobe_i) begin
      if (!en_level_i) begin
        addr_d = {bit_val_i, addr_q[ADDR_W-1:1]};
      end else begin
        shreg_d = {bit_val_i, shreg_q[PAYLOAD_W-1:1]};
        if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      match_q <= 1'b0;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      addr_q  <= addr_d;
      match_q <= match_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign payload_o = shreg_q;
  assign accept_o  = en_fall_i & match_q & (cnt_q == CNT_FULL);
endmodule

// File: rtl/vfdrx_store.sv
module vfdrx_store
  import vfdrx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 load_d1_o,
  output logic                 load_d2_o,
  output logic [SEG_N-1:0]     d1_o,
  output logic [SEG_N-1:0]     d2_o,
  output logic [DIM_W-1:0]     dim_o
);
  frame_sel_e           sel;
  logic [SEG_N-1:0]     d1_q, d1_d, d2_q, d2_d;
  logic [DIM_W-1:0]     dim_q, dim_d;

  assign sel       = frame_sel_e'(payload_i[SEL_POS]);
  assign load_d1_o = accept_i & (sel == FRAME_DIGIT1);
  assign load_d2_o = accept_i & (sel == FRAME_DIGIT2);

  always_comb begin
    d1_d  = d1_q;
    d2_d  = d2_q;
    dim_d = dim_q;
    if (load_d1_o) d1_d = payload_i[SEG_N-1:0];
    if (load_d2_o) begin
      d2_d  = payload_i[SEG_N-1:0];
      dim_d = payload_i[DIM_LSB +: DIM_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q  <= '0;
      d2_q  <= '0;
      dim_q <= '0;
    end else begin
      d1_q  <= d1_d;
      d2_q  <= d2_d;
      dim_q <= dim_d;
    end
  end

  assign d1_o  = d1_q;
  assign d2_o  = d2_q;
  assign dim_o = dim_q;
endmodule

// File: rtl/vfd_serial_rx.sv
module vfd_serial_rx
  import vfdrx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_en_i,
  input  logic             blank_n_i,
  output logic [SEG_N-1:0] seg_g1_o,
  output logic [SEG_N-1:0] seg_g2_o,
  output logic [DIM_W-1:0] dimmer_o
);
  localparam int LN_CLK = 0;
  localparam int LN_DAT = 1;
  localparam int LN_EN  = 2;

  logic [2:0]           lvl, rise, fall;
  logic [PAYLOAD_W-1:0] payload;
  logic                 accept;
  logic                 commit_g1, commit_g2;
  logic [SEG_N-1:0]     g1_q, g2_q;
  logic [DIM_W-1:0]     dim_q;

  vfdrx_sync #(.W(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_en_i, ser_dat_i, ser_clk_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  vfdrx_shifter u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_strobe_i (rise[LN_CLK]),
    .bit_val_i    (lvl[LN_DAT]),
    .en_level_i   (lvl[LN_EN]),
    .en_rise_i    (rise[LN_EN]),
    .en_fall_i    (fall[LN_EN]),
    .payload_o    (payload),
    .accept_o     (accept)
  );

  vfdrx_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .payload_i (payload),
    .load_d1_o (commit_g1),
    .load_d2_o (commit_g2),
    .d1_o      (g1_q),
    .d2_o      (g2_q),
    .dim_o     (dim_q)
  );

  assign seg_g1_o = g1_q & {SEG_N{blank_n_i}};
  assign seg_g2_o = g2_q & {SEG_N{blank_n_i}};
  assign dimmer_o = dim_q;
endmodule

// File: rtl/vfd_serial_rx_chk.sv
module vfd_serial_rx_chk #(
  parameter int SEG_N = 53,
  parameter int DIM_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_en_i,
  input logic             commit_g1,
  input logic             commit_g2,
  input logic [SEG_N-1:0] g1_q,
  input logic [SEG_N-1:0] g2_q,
  input logic [DIM_W-1:0] dim_q
);
  a_r5_commit_after_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_g1 || commit_g2) |-> !$past(ser_en_i, 2));

  a_r6_one_frame_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_g1, commit_g2}));

  a_r6_g1_moves_on_own_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(g1_q) |-> $past(commit_g1));

  a_r4_g2_moves_on_own_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(g2_q) |-> $past(commit_g2));

  a_r4_dim_moves_with_g2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dim_q) |-> $past(commit_g2));
endmodule

bind vfd_serial_rx vfd_serial_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_en_i  (ser_en_i),
  .commit_g1 (commit_g1),
  .commit_g2 (commit_g2),
  .g1_q      (g1_q),
  .g2_q      (g2_q),
  .dim_q     (dim_q)
);

// File: tb/vfd_serial_rx_tb.sv
module vfd_serial_rx_tb;
  localparam int H = 4;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0, blank_n = 1'b1;
  logic [52:0] seg_g1, seg_g2;
  logic [9:0]  dimmer;

  logic [52:0] m_g1, m_g2;
  logic [9:0]  m_dim;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vfd_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_en_i(ser_en), .blank_n_i(blank_n),
    .seg_g1_o(seg_g1), .seg_g2_o(seg_g2), .dimmer_o(dimmer)
  );

  // {address, payload, payload bit count, clock rests high}
  localparam logic [79:0] VEC [NV] = '{
    {8'h21, 64'h7E95_0123_4567_89AB, 7'd64, 1'b0},
    {8'h21, 64'hFFC1_5555_AAAA_3333, 7'd64, 1'b1},
    {8'h22, 64'h0000_0000_0000_0000, 7'd64, 1'b0},
    {8'h21, 64'h0000_0000_0000_0000, 7'd63, 1'b0},
    {8'h21, 64'h8000_0000_0000_0000, 7'd65, 1'b1},
    {8'h21, 64'h0012_3456_789A_BCDE, 7'd64, 1'b1},
    {8'h21, 64'h9FE0_0000_0000_0001, 7'd64, 1'b0},
    {8'hA1, 64'h0000_0000_0000_0000, 7'd64, 1'b1},
    {8'h20, 64'h8000_0000_0000_0000, 7'd64, 1'b0}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic idle_hi);
    if (idle_hi) begin
      ser_clk = 1'b0; ser_dat = b; wait_n(H);
      ser_clk = 1'b1; wait_n(H);
    end else begin
      ser_dat = b; wait_n(H);
      ser_clk = 1'b1; wait_n(H);
      ser_clk = 1'b0;
    end
  endtask

  // Ends on the negedge where the enable has just been driven low.
  task automatic send_frame(input logic [7:0] addr, input logic [63:0] pl,
                            input int nbits, input logic idle_hi);
    ser_clk = idle_hi; ser_en = 1'b0; wait_n(H);
    for (int i = 0; i < 8; i++) send_bit(addr[i], idle_hi);
    wait_n(H); ser_en = 1'b1; wait_n(H);
    for (int i = 0; i < nbits; i++) send_bit(pl[i % 64], idle_hi);
    wait_n(H); ser_en = 1'b0;
  endtask

  task automatic model(input logic [7:0] addr, input logic [63:0] pl, input int nbits);
    if (addr == 8'h21 && nbits == 64) begin
      if (!pl[63]) m_g1 = pl[52:0];
      else begin m_g2 = pl[52:0]; m_dim = pl[62:53]; end
    end
  endtask

  task automatic check_all(input string req);
    check(req, {11'd0, seg_g1}, {11'd0, m_g1});
    check(req, {11'd0, seg_g2}, {11'd0, m_g2});
    check(req, {54'd0, dimmer}, {54'd0, m_dim});
  endtask

  initial begin
    m_g1 = '0; m_g2 = '0; m_dim = '0;
    wait_n(3);
    // R1: reset state, during and after reset
    check_all("R1 during reset");
    rst_n = 1'b1;
    wait_n(2);
    check_all("R1 after reset");

    // Vector table: R2 address, R3/R4 layout, R5 count, R6 isolation, R7 idle level
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][79:72], VEC[v][71:8], int'(VEC[v][7:1]), VEC[v][0]);
      wait_n(6);
      model(VEC[v][79:72], VEC[v][71:8], int'(VEC[v][7:1]));
      check_all($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", v));
    end

    // R9: commit lands on the third rising edge after enable falls
    send_frame(8'h21, 64'h0000_0000_0000_0F0F, 64, 1'b0);
    wait_n(2);
    check("R9 before commit", {11'd0, seg_g1}, {11'd0, m_g1});
    wait_n(1);
    model(8'h21, 64'h0000_0000_0000_0F0F, 64);
    check("R9 at commit", {11'd0, seg_g1}, {11'd0, m_g1});

    // R8: blanking zeroes segments, reception continues
    blank_n = 1'b0;
    wait_n(1);
    check("R8 blank g1", {11'd0, seg_g1}, 64'd0);
    check("R8 blank g2", {11'd0, seg_g2}, 64'd0);
    send_frame(8'h21, 64'hC020_0000_0000_00FF, 64, 1'b1);
    wait_n(6);
    model(8'h21, 64'hC020_0000_0000_00FF, 64);
    check("R8 blanked g2 stays zero", {11'd0, seg_g2}, 64'd0);
    check("R8 dimmer during blank", {54'd0, dimmer}, {54'd0, m_dim});
    blank_n = 1'b1;
    wait_n(1);
    check_all("R8 after unblank");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule